// File: doc/BRIEF.md
# Linear Block to Cylinder/Head/Sector Command Encoder

This block turns a linear block number and a transfer length in bytes into the four 16-bit argument words of a disk read or write command. It also produces the matching command code. The drive geometry is given alongside each request as the number of sectors on a track and the number of heads. A bit-serial restoring divider computes the position in two passes. The first pass divides the block number by the sectors per track, which gives the track and the sector. The second pass divides the track by the head count, which gives the cylinder and the head.

A request is a one-cycle `start` pulse. The inputs are sampled on that edge. A one-cycle `done` pulse follows once both divisions have finished. The four words and the code stay on the outputs until the next successful request. If either geometry field is zero, the block does not divide: it reports an error at once and leaves the previous words on the outputs.

Word 2 packs the low five cylinder bits above a reserved zero bit, the head field and the sector field. Word 3 carries the five upper cylinder bits. The cylinder is therefore 10 bits wide.

Top module: `chs_cmd_encoder`

## Requirements
- R1: While reset is held and after it is released, `done` and `error` are low, `cmdCode` is 0 and all four words are 0.
- R2: The sector is the block number modulo the sectors per track. It appears in word 2 bits 4:0. The track is the block number divided by the sectors per track.
- R3: Word 2 bits 9:5 hold the head, which is the track modulo the head count. Bits 15:11 hold cylinder bits 4:0, where the cylinder is the track divided by the head count. Bit 10 is 0.
- R4: Word 3 bits 4:0 hold cylinder bits 9:5 and bits 15:5 are 0. Cylinder bits above bit 9 are dropped.
- R5: After a successful request, word 0 is 0x0002.
- R6: Word 1 is the byte count divided by 512, truncated to 16 bits.
- R7: `cmdCode` is 0x01 when `isWrite` is 0 and 0x02 when `isWrite` is 1.
- R8: On a request with nonzero geometry, `done` is high for exactly one cycle with `error` low. That cycle begins 2*BLK_W+2 clock edges after the edge that sampled `start`. The words and code then hold until the next successful request.
- R9: When `start` is sampled with zero sectors per track or zero heads, `done` and `error` are both high during the next cycle only, and the words and code are unchanged.
- R10: A `start` that arrives while a request is in progress is ignored. The first request's results and timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; inputs are sampled with it |
| blockNum | input | BLK_W (24) | Linear block number |
| byteCount | input | BYTE_W (25) | Transfer length in bytes |
| spt | input | GEO_W (5) | Sectors per track |
| heads | input | GEO_W (5) | Number of heads |
| isWrite | input | 1 | 1 selects the write command, 0 the read command |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High together with `done` when the geometry was zero |
| cmdCode | output | 5 | Command code of the last successful request |
| word0 | output | 16 | Option word |
| word1 | output | 16 | Block count |
| word2 | output | 16 | Cylinder low bits, head and sector |
| word3 | output | 16 | Cylinder high bits |

## Verification
The table walks block numbers from zero through the largest 24-bit value, across geometries of one sector and one head up to 31 of each. This separates a correct quotient and remainder from an off-by-one in the restoring step and from a swap of the two divisors. The all-ones block number gives a cylinder wider than 10 bits, so it shows whether word 3 truncates correctly. Byte counts just below and at multiples of 512 confirm the floor division in word 1, and alternating the direction flag confirms the code selection. Directed runs then cover zero sectors and zero heads, a second start during a busy run, and holding of the results after `done`.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam logic [4:0] CODE_READ  = 5'h01;
  localparam logic [4:0] CODE_WRITE = 5'h02;
  localparam logic [15:0] OPTION_WORD = 16'h0002;
  localparam int FIELD_W = 5;
  localparam int BLK_SHIFT = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_DIV1, S_MID, S_DIV2, S_FIN, S_DONE, S_ERR
  } stateT;

  typedef struct packed {
    logic capture;   // sample request, load first division
    logic step;      // one restoring step
    logic useHeads;  // divisor select: heads instead of sectors
    logic second;    // keep sector, load second division
    logic finish;    // publish results
  } strobeT;
endpackage

// File: rtl/chs_div.sv
module chs_div #(
  parameter int W  = 24,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic [W-1:0]  quotient,
  output logic [DW-1:0] remainder
);
  logic [DW-1:0] remR;
  logic [W-1:0]  quoR;
  logic [DW:0]   shifted;
  logic [DW:0]   trial;

  always_comb begin
    shifted = {remR, quoR[W-1]};
    trial   = shifted - {1'b0, divisor};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remR <= '0;
      quoR <= '0;
    end else if (load) begin
      remR <= '0;
      quoR <= dividend;
    end else if (step) begin
      if (!trial[DW]) begin
        remR <= trial[DW-1:0];
        quoR <= {quoR[W-2:0], 1'b1};
      end else begin
        remR <= shifted[DW-1:0];
        quoR <= {quoR[W-2:0], 1'b0};
      end
    end
  end

  assign quotient  = quoR;
  assign remainder = remR;
endmodule

// File: rtl/chs_ctrl.sv
module chs_ctrl
  import chs_pkg::*;
#(
  parameter int BLK_W = 24,
  parameter int GEO_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GEO_W-1:0] spt,
  input  logic [GEO_W-1:0] heads,
  output strobeT           strb,
  output logic             done,
  output logic             error
);
  localparam int CNT_W = $clog2(BLK_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_W - 1);

  stateT state, nxt;
  logic [CNT_W-1:0] stepCnt;
  logic lastStep, geoZero;

  assign lastStep = (stepCnt == LAST);
  assign geoZero  = (spt == '0) || (heads == '0);

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      S_IDLE: if (start) begin
        if (geoZero) nxt = S_ERR;
        else begin
          strb.capture = 1'b1;
          nxt = S_DIV1;
        end
      end
      S_DIV1: begin
        strb.step = 1'b1;
        if (lastStep) nxt = S_MID;
      end
      S_MID: begin
        strb.second = 1'b1;
        nxt = S_DIV2;
      end
      S_DIV2: begin
        strb.step = 1'b1;
        strb.useHeads = 1'b1;
        if (lastStep) nxt = S_FIN;
      end
      S_FIN: begin
        strb.finish = 1'b1;
        strb.useHeads = 1'b1;
        nxt = S_DONE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state <= nxt;
      if (strb.step && !lastStep) stepCnt <= stepCnt + 1'b1;
      else stepCnt <= '0;
    end
  end

  assign done  = (state == S_DONE) || (state == S_ERR);
  assign error = (state == S_ERR);
endmodule

// File: rtl/chs_datapath.sv
module chs_datapath
  import chs_pkg::*;
#(
  parameter int BLK_W  = 24,
  parameter int BYTE_W = 25,
  parameter int GEO_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobeT            strb,
  input  logic [BLK_W-1:0]  blockNum,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic [GEO_W-1:0]  spt,
  input  logic [GEO_W-1:0]  heads,
  input  logic              isWrite,
  output logic [4:0]        cmdCode,
  output logic [15:0]       word0,
  output logic [15:0]       word1,
  output logic [15:0]       word2,
  output logic [15:0]       word3
);
  logic [GEO_W-1:0] sptR, headsR, sectorR, divisor, remainder;
  logic [BLK_W-1:0] quotient, dividend;
  logic [15:0]      countP;
  logic [4:0]       codeP;

  assign divisor  = strb.useHeads ? headsR : sptR;
  assign dividend = strb.second ? quotient : blockNum;

  chs_div #(.W(BLK_W), .DW(GEO_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (strb.capture | strb.second),
    .step     (strb.step),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .remainder(remainder)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sptR    <= '0;
      headsR  <= '0;
      sectorR <= '0;
      countP  <= '0;
      codeP   <= '0;
      cmdCode <= '0;
      word0   <= '0;
      word1   <= '0;
      word2   <= '0;
      word3   <= '0;
    end else begin
      if (strb.capture) begin
        sptR   <= spt;
        headsR <= heads;
        countP <= 16'(byteCount >> BLK_SHIFT);
        codeP  <= isWrite ? CODE_WRITE : CODE_READ;
      end
      if (strb.second) sectorR <= remainder;
      if (strb.finish) begin
        cmdCode <= codeP;
        word0   <= OPTION_WORD;
        word1   <= countP;
        word2   <= {quotient[FIELD_W-1:0], 1'b0,
                    remainder[FIELD_W-1:0], sectorR[FIELD_W-1:0]};
        word3   <= {11'b0, quotient[2*FIELD_W-1:FIELD_W]};
      end
    end
  end
endmodule

// File: rtl/chs_cmd_encoder.sv
module chs_cmd_encoder
  import chs_pkg::*;
#(
  parameter int BLK_W  = 24,
  parameter int BYTE_W = 25,
  parameter int GEO_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  blockNum,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic [GEO_W-1:0]  spt,
  input  logic [GEO_W-1:0]  heads,
  input  logic              isWrite,
  output logic              done,
  output logic              error,
  output logic [4:0]        cmdCode,
  output logic [15:0]       word0,
  output logic [15:0]       word1,
  output logic [15:0]       word2,
  output logic [15:0]       word3
);
  strobeT strb;

  chs_ctrl #(.BLK_W(BLK_W), .GEO_W(GEO_W)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .spt  (spt),
    .heads(heads),
    .strb (strb),
    .done (done),
    .error(error)
  );

  chs_datapath #(.BLK_W(BLK_W), .BYTE_W(BYTE_W), .GEO_W(GEO_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .blockNum (blockNum),
    .byteCount(byteCount),
    .spt      (spt),
    .heads    (heads),
    .isWrite  (isWrite),
    .cmdCode  (cmdCode),
    .word0    (word0),
    .word1    (word1),
    .word2    (word2),
    .word3    (word3)
  );
endmodule

// File: rtl/chs_cmd_encoder_chk.sv
module chs_cmd_encoder_chk
  import chs_pkg::*;
#(
  parameter int GEO_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [GEO_W-1:0] spt,
  input logic [GEO_W-1:0] heads,
  input logic             done,
  input logic             error,
  input logic [4:0]       cmdCode,
  input logic [15:0]      word0,
  input logic [15:0]      word2,
  input logic [15:0]      word3
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  a_r9_error_cause: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> $past(start) && ($past(spt) == '0 || $past(heads) == '0));

  a_r8_publish_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(word2) || !$stable(word3)) |-> (done && !error));

  a_r5_option_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> word0 == OPTION_WORD);

  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (cmdCode == CODE_READ || cmdCode == CODE_WRITE));

  a_r3_gap_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !word2[10]);

  a_r4_word3_upper: assert property (@(posedge clk) disable iff (!rst_n)
    word3[15:5] == '0);
endmodule

bind chs_cmd_encoder chs_cmd_encoder_chk #(.GEO_W(GEO_W)) u_chk (.*);

// File: tb/tb_chs_cmd_encoder.sv
module tb_chs_cmd_encoder;
  localparam int BLK_W = 24;
  localparam int BYTE_W = 25;
  localparam int GEO_W = 5;
  localparam int LAT = 2 * BLK_W + 2 + 1;  // negedges from drive to done
  localparam int NVEC = 6;
  // {blockNum, byteCount, spt, heads, isWrite}
  localparam logic [59:0] VEC [NVEC] = '{
    {24'd0,        25'd512,       5'd17, 5'd4,  1'b0},
    {24'd1000,     25'd4096,      5'd17, 5'd7,  1'b1},
    {24'hFFFFFF,   25'h1FFFFFF,   5'd31, 5'd31, 1'b0},
    {24'd63,       25'd1023,      5'd1,  5'd1,  1'b1},
    {24'd12345,    25'd511,       5'd31, 5'd15, 1'b0},
    {24'd30,       25'd1536,      5'd31, 5'd2,  1'b1}
  };

  logic clk = 0, rst_n = 0, start = 0, isWrite = 0;
  logic [BLK_W-1:0] blockNum = '0;
  logic [BYTE_W-1:0] byteCount = '0;
  logic [GEO_W-1:0] spt = '0, heads = '0;
  logic done, error;
  logic [4:0] cmdCode;
  logic [15:0] word0, word1, word2, word3;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  chs_cmd_encoder #(.BLK_W(BLK_W), .BYTE_W(BYTE_W), .GEO_W(GEO_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blockNum(blockNum),
    .byteCount(byteCount), .spt(spt), .heads(heads), .isWrite(isWrite),
    .done(done), .error(error), .cmdCode(cmdCode), .word0(word0),
    .word1(word1), .word2(word2), .word3(word3)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [59:0] v);
    blockNum  = v[59:36];
    byteCount = v[35:11];
    spt       = v[10:6];
    heads     = v[5:1];
    isWrite   = v[0];
  endtask

  // drive one request and wait for done; lat counts negedges
  task automatic runReq(logic [59:0] v, output int lat);
    @(negedge clk);
    apply(v);
    start = 1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 0;
      lat++;
    end while (!done && lat < 200);
  endtask

  function automatic logic [15:0] expW2(logic [59:0] v);
    longint unsigned trk, sec, hd, cyl;
    trk = v[59:36] / v[10:6];
    sec = v[59:36] % v[10:6];
    hd  = trk % v[5:1];
    cyl = trk / v[5:1];
    return {cyl[4:0], 1'b0, hd[4:0], sec[4:0]};
  endfunction

  function automatic logic [15:0] expW3(logic [59:0] v);
    longint unsigned cyl;
    cyl = (v[59:36] / v[10:6]) / v[5:1];
    return {11'b0, cyl[9:5]};
  endfunction

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] h1, h2, h3;
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 error in reset", error, 0);
    check("R1 words in reset", {word0, word1}, 0);
    check("R1 words2/3 in reset", {word2, word3}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 code after reset", cmdCode, 0);

    for (int i = 0; i < NVEC; i++) begin
      runReq(VEC[i], lat);
      check("R8 latency", lat, LAT);
      check("R8 error low on success", error, 0);
      check("R2 sector field", word2[4:0], expW2(VEC[i]) & 16'h1F);
      check("R3 head/cyl fields", word2[15:5], expW2(VEC[i]) >> 5);
      check("R4 word3", word3, expW3(VEC[i]));
      check("R5 word0", word0, 16'h0002);
      check("R6 word1", word1, 16'(VEC[i][35:11] >> 9));
      check("R7 code", cmdCode, VEC[i][0] ? 5'h02 : 5'h01);
    end

    // R8 hold after done
    h1 = word1; h2 = word2; h3 = word3;
    repeat (3) @(negedge clk);
    check("R8 done pulse ends", done, 0);
    check("R8 words hold", {h1, h2, h3} == {word1, word2, word3}, 1);

    // R9 zero sectors per track
    runReq({24'd77, 25'd2048, 5'd0, 5'd3, 1'b1}, lat);
    check("R9 spt zero latency", lat, 1);
    check("R9 spt zero error", error, 1);
    check("R9 words unchanged", {word1, word2, word3} == {h1, h2, h3}, 1);
    check("R9 code unchanged", cmdCode, 5'h02);
    @(negedge clk);
    check("R9 error one cycle", {done, error}, 0);
    // R9 zero heads
    runReq({24'd77, 25'd2048, 5'd9, 5'd0, 1'b0}, lat);
    check("R9 heads zero latency", lat, 1);
    check("R9 heads zero error", error, 1);
    check("R9 heads zero words", {word1, word2, word3} == {h1, h2, h3}, 1);

    // R10 start during busy
    @(negedge clk);
    apply(VEC[1]);
    start = 1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 0;
      lat++;
      if (lat == 10) begin
        apply(VEC[2]);
        start = 1;
      end
    end while (!done && lat < 200);
    check("R10 latency unaffected", lat, LAT);
    check("R10 word2 of first request", word2, expW2(VEC[1]));
    check("R10 word1 of first request", word1, 16'(VEC[1][35:11] >> 9));
    check("R10 code of first request", cmdCode, 5'h02);
    repeat (3) @(negedge clk);
    check("R10 no second done", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule